// File: doc/BRIEF.md
# Serial Audio Receive Deserializer

This block turns a one-bit serial audio stream into parallel words for a receive buffer. It runs entirely in the system clock domain. Edges of the bit clock, or of a gated clock, reach it as single-cycle enable pulses. On each qualified pulse it samples the data input. When the last bit of a word has been taken, it presents the assembled word left-justified in a 24-bit output and raises a one-cycle valid strobe.

Two clock modes are supported:

- **Continuous-clock mode.** The bit clock runs all the time, and only pulses that arrive while the frame-sync input is high are counted as data.
- **Gated-clock mode.** Every pulse carries a data bit and the frame-sync input is ignored.

Words arrive either most-significant bit first or least-significant bit first. The programmable length runs from 8 to 24 bits in steps of two. A short word is placed in the upper output positions, and the unused low bits are zero.

Top module: `srx_deser`

## Requirements
- R1: After reset, `word_out` is all zeros and `word_valid` is low.
- R2: With `lsb_first` = 0, the first bit received becomes the most significant bit of the word, which lands at `word_out[23]`.
- R3: With `lsb_first` = 1, the first bit received becomes the least significant bit of the word. That bit lands at `word_out[24 - len]`, and the last bit lands at `word_out[23]`.
- R4: `word_len` is an even value from 8 to 24. For a word of length `len`, `word_out[23 -: len]` holds the word and the low `24 - len` bits are zero.
- R5: With `gated_mode` = 0, an enable pulse while `fsync` is low neither shifts a bit nor counts toward the word.
- R6: With `gated_mode` = 1, every enable pulse takes one bit, whatever the level of `fsync`.
- R7: `word_valid` is high for exactly one cycle: the cycle after the clock edge at which the last bit of a word was sampled. It stays low while a word is incomplete.
- R8: `word_len` is sampled at the first bit of each word. A change made mid-word takes effect from the next word.
- R9: Words sent back to back, with the first bit of the next word at the pulse right after the last bit of the previous word, are each delivered correctly.
- R10: `word_out` holds the last completed word until the next word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk_en | input | 1 | One-cycle pulse marking a sampling edge of the bit or gated clock |
| fsync | input | 1 | Frame sync; qualifies pulses in continuous-clock mode |
| gated_mode | input | 1 | 1 = gated-clock mode, 0 = continuous-clock mode |
| lsb_first | input | 1 | 1 = least significant bit first, 0 = most significant bit first |
| word_len | input | 5 | Word length in bits (even, 8 to 24) |
| sdata | input | 1 | Serial data input |
| word_out | output | 24 | Last completed word, left-justified |
| word_valid | output | 1 | One-cycle strobe marking a new word on `word_out` |

## Verification
The assertions take it as given that `word_len` always holds a legal even length from 8 to 24. They also assume that `lsb_first` and `gated_mode` change only between words, never inside one. The directed stimulus sets length, order and mode before a word's first bit. The only exception is the one scenario that changes `word_len` deliberately mid-word, to show it is ignored until the next word. Enable pulses are held one cycle wide, matching the edge-pulse contract, and noise pulses with frame sync low appear only in continuous-clock mode, where they must be rejected.

// File: rtl/srx_pkg.sv
// Package srx_pkg: shared constants and types for the serial receive deserializer.
package srx_pkg;
    localparam int unsigned SRX_MAX_W = 24;
    localparam int unsigned SRX_MIN_W = 8;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } srx_order_e;
endpackage

// File: rtl/srx_bit_counter.sv
// srx_bit_counter: counts the accepted bits of the current word.
// The word length is captured on the first bit, so a word always completes
// at the length that was in force when it began.
// Assumes len_in is even and within MIN_W..W whenever a word starts.
module srx_bit_counter #(
    parameter int unsigned W     = srx_pkg::SRX_MAX_W,
    parameter int unsigned MIN_W = srx_pkg::SRX_MIN_W,
    localparam int unsigned CW   = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] len_in,
    output logic          first_bit,
    output logic          last_bit,
    output logic [CW-1:0] len_eff
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;

    // Length in force: the live input at a word's first bit, the captured value after it.
    always_comb begin
        first_bit = (cnt_q == '0);
        len_eff   = first_bit ? len_in : len_q;
        last_bit  = step && (cnt_q == len_eff - CW'(1));
    end

    // Bit count and length capture, advanced only on accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= CW'(MIN_W);
        end else if (step) begin
            if (first_bit) len_q <= len_in;
            cnt_q <= last_bit ? '0 : cnt_q + CW'(1);
        end
    end

    // The count may move only when a bit is accepted.
    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));

    // Mid-word, the count stays below the length captured at the word's first bit.
    assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q < len_q));
endmodule

// File: rtl/srx_shift_reg.sv
// srx_shift_reg: the 24-bit receive shift register.
// MSB-first words enter at bit 0 and build up right-aligned.
// LSB-first words enter at the top and build downward, so they end up left-justified.
// The register is cleared at each word's first bit, so stale bits never leak into a short word.
// Assumes the bit order stays constant for the whole word.
module srx_shift_reg #(
    parameter int unsigned W = srx_pkg::SRX_MAX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                first_bit,
    input  srx_pkg::srx_order_e order,
    input  logic                sdata,
    output logic [W-1:0]        sh_next
);
    logic [W-1:0] sh_q;
    logic [W-1:0] base;

    // Next register contents when the current bit is accepted.
    always_comb begin
        base = first_bit ? '0 : sh_q;
        if (order == srx_pkg::ORDER_LSB) sh_next = {sdata, base[W-1:1]};
        else                             sh_next = {base[W-2:0], sdata};
    end

    // Load the shifted value on accepted bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)    sh_q <= '0;
        else if (step) sh_q <= sh_next;
    end

    // Unqualified pulses must leave the register untouched.
    assert_sh_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(sh_q));
endmodule

// File: rtl/srx_justify.sv
// srx_justify: combinational left-justification of a completed word.
// MSB-first words are moved up by W - len; LSB-first words are already in place.
// Assumes len lies within 1..W.
module srx_justify #(
    parameter int unsigned W  = srx_pkg::SRX_MAX_W,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]        raw,
    input  logic [CW-1:0]       len,
    input  srx_pkg::srx_order_e order,
    output logic [W-1:0]        justified
);
    localparam logic [CW-1:0] W_C = CW'(W);

    logic [CW-1:0] shamt;

    // Shift amount and placement of the word.
    always_comb begin
        shamt = W_C - len;
        if (order == srx_pkg::ORDER_LSB) justified = raw;
        else                             justified = raw << shamt;
    end
endmodule

// File: rtl/srx_deser.sv
// srx_deser: serial-to-parallel receiver for audio words of 8 to 24 bits.
// Accepts a bit on each bclk_en pulse. In continuous-clock mode the pulse must
// also arrive while fsync is high; in gated-clock mode fsync is ignored.
// Registers the left-justified word and raises word_valid for one cycle
// after the last bit of the word.
// Assumes word_len is even, 8..24, and that mode inputs change only between words.
module srx_deser #(
    parameter int unsigned W     = srx_pkg::SRX_MAX_W,
    parameter int unsigned MIN_W = srx_pkg::SRX_MIN_W,
    localparam int unsigned CW   = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_en,
    input  logic          fsync,
    input  logic          gated_mode,
    input  logic          lsb_first,
    input  logic [CW-1:0] word_len,
    input  logic          sdata,
    output logic [W-1:0]  word_out,
    output logic          word_valid
);
    logic                step;
    logic                first_bit;
    logic                last_bit;
    logic [CW-1:0]       len_eff;
    logic [W-1:0]        sh_next;
    logic [W-1:0]        just;
    srx_pkg::srx_order_e order;

    // Qualify edge pulses according to the clock mode.
    always_comb begin
        step  = bclk_en && (gated_mode || fsync);
        order = srx_pkg::srx_order_e'(lsb_first);
    end

    srx_bit_counter #(.W(W), .MIN_W(MIN_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .len_in    (word_len),
        .first_bit (first_bit),
        .last_bit  (last_bit),
        .len_eff   (len_eff)
    );

    srx_shift_reg #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .first_bit (first_bit),
        .order     (order),
        .sdata     (sdata),
        .sh_next   (sh_next)
    );

    srx_justify #(.W(W)) u_just (
        .raw       (sh_next),
        .len       (len_eff),
        .order     (order),
        .justified (just)
    );

    // Output stage: capture the finished word and pulse the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= last_bit;
            if (last_bit) word_out <= just;
        end
    end

    // The strobe never lasts two cycles.
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // The strobe always follows an edge pulse on the previous cycle.
    assert_valid_after_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(bclk_en));

    // In continuous-clock mode, a word can finish only on a frame-qualified pulse.
    assert_frame_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(gated_mode || fsync));

    // The bits below a short word read as zero.
    assert_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ((word_out & ({W{1'b1}} >> u_cnt.len_q)) == '0));

    // Word holds between completions.
    assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(word_out) || word_valid);
endmodule

// File: tb/srx_deser_bench.sv
// srx_deser_bench: directed bench, one task per scenario, each checking its own results.
module srx_deser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_en = 1'b0;
    logic        fsync = 1'b0;
    logic        gated_mode = 1'b0;
    logic        lsb_first = 1'b0;
    logic [4:0]  word_len = 5'd24;
    logic        sdata = 1'b0;
    logic [23:0] word_out;
    logic        word_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    srx_deser u_srx_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_en    (bclk_en),
        .fsync      (fsync),
        .gated_mode (gated_mode),
        .lsb_first  (lsb_first),
        .word_len   (word_len),
        .sdata      (sdata),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_word(input logic [23:0] val, input int len);
        logic [23:0] m;
        m = (len >= 24) ? 24'hFFFFFF : ((24'd1 << len) - 24'd1);
        return (val & m) << (24 - len);
    endfunction

    function automatic logic bit_at(input logic [23:0] val, input int len, input bit lsb, input int i);
        return lsb ? val[i] : val[len - 1 - i];
    endfunction

    // Send one word; noise adds rejected pulses (fsync low), gap adds idle cycles,
    // new_len != 0 changes word_len after the third bit.
    task automatic send_word(input string req, input logic [23:0] val, input int len,
                             input bit lsb, input bit gated, input bit fs,
                             input bit noise, input bit gap, input int new_len);
        bit early = 1'b0;
        @(negedge clk);
        word_len = 5'(len); lsb_first = lsb; gated_mode = gated;
        for (int i = 0; i < len; i++) begin
            if (noise) begin
                bclk_en = 1'b1; fsync = 1'b0; sdata = ~bit_at(val, len, lsb, i);
                @(negedge clk);
                if (word_valid) early = 1'b1;
            end
            bclk_en = 1'b1; fsync = fs; sdata = bit_at(val, len, lsb, i);
            @(negedge clk);
            if (word_valid && i < len - 1) early = 1'b1;
            if (i == 2 && new_len != 0) word_len = 5'(new_len);
            if (gap && i < len - 1) begin
                bclk_en = 1'b0;
                @(negedge clk);
                if (word_valid) early = 1'b1;
            end
        end
        bclk_en = 1'b0; fsync = 1'b0;
        check({req, " R7 no early valid"}, 32'(early), 32'd0);
        check({req, " R7 valid after last bit"}, 32'(word_valid), 32'd1);
        check({req, " word"}, 32'(word_out), 32'(expect_word(val, len)));
        @(negedge clk);
        check({req, " R7 single-cycle valid"}, 32'(word_valid), 32'd0);
        word_len = 5'd24;
    endtask

    task automatic test_reset();
        check("R1 reset word", 32'(word_out), 32'd0);
        check("R1 reset valid", 32'(word_valid), 32'd0);
    endtask

    // R9: two words with no idle cycle between them.
    task automatic test_back_to_back();
        logic [23:0] a = 24'h00A5C3;
        logic [23:0] b = 24'h00003C;
        @(negedge clk);
        word_len = 5'd16; lsb_first = 1'b0; gated_mode = 1'b0;
        for (int i = 0; i < 16; i++) begin
            bclk_en = 1'b1; fsync = 1'b1; sdata = a[15 - i];
            @(negedge clk);
        end
        word_len = 5'd8;
        for (int i = 0; i < 8; i++) begin
            bclk_en = 1'b1; fsync = 1'b1; sdata = b[7 - i];
            if (i == 0) begin
                check("R9 first word valid", 32'(word_valid), 32'd1);
                check("R9 first word", 32'(word_out), 32'(expect_word(a, 16)));
            end
            @(negedge clk);
        end
        bclk_en = 1'b0; fsync = 1'b0;
        check("R9 second word valid", 32'(word_valid), 32'd1);
        check("R9 second word", 32'(word_out), 32'(expect_word(b, 8)));
        @(negedge clk);
    endtask

    // R10 and R5: rejected pulses neither change the word nor raise valid.
    task automatic test_hold();
        logic [23:0] prev;
        @(negedge clk);
        prev = word_out;
        gated_mode = 1'b0;
        for (int i = 0; i < 30; i++) begin
            bclk_en = 1'b1; fsync = 1'b0; sdata = i[0];
            @(negedge clk);
        end
        bclk_en = 1'b0;
        check("R10 word held", 32'(word_out), 32'(prev));
        check("R5 no valid from unframed pulses", 32'(word_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        send_word("R2 msb-first 24", 24'hD2B471, 24, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        send_word("R3 lsb-first 24", 24'h3C81E5, 24, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        send_word("R4 msb-first 8",  24'h0000B7, 8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        send_word("R4 lsb-first 16", 24'h00C35A, 16, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        send_word("R4 msb-first 18", 24'h02A5F1, 18, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        send_word("R5 noise pulses", 24'h00964B, 20, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0);
        send_word("R6 gated no fsync", 24'h0000E9, 10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0);
        send_word("R6 gated msb",   24'h00F00F, 16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0);
        send_word("R8 len change mid-word", 24'h00ABCD, 16, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8);
        test_back_to_back();
        test_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule